// File: doc/BRIEF.md
# Vectored Interrupt Capture and Dispatch

This block holds per-line interrupt state for a parameterised set of input lines (up to 64) and drives a bank of output interrupt wires. Each line is configured as edge or level sensitive, may be masked, and carries a vector that names the output wire it drives. Internally the block keeps three line-wide vectors: raw pending, in-service and the last level seen on each input.

Every clock the block takes at most one event. An event is either a change on one input line or a change in the mask configuration. A rising event dispatches the lowest-numbered eligible line: that line is marked in service and its vectored output is set. A falling event retires the lowest-numbered in-service line of the event set: its in-service bit is cleared and its vectored output is cleared. Outputs are registered levels.

No data stream passes through this block, so it has no valid/ready handshake: the line inputs are levels, the configuration inputs are static words sampled every clock, and the outputs are plain levels. The bus register interface and polarity inversion sit outside the block.

Top module: `vec_irq_dispatch`

## Requirements
- R1: For a line whose edge bit is 1, the pending bit is set only when the input rises while the stored last-seen level is 0; a falling input leaves it set. The last-seen level always takes the input value when the line's change is processed.
- R2: For a line whose edge bit is 0, the pending bit and the last-seen level both take the input level when the line's change is processed.
- R3: On a rising event, the eligible set is pending AND NOT mask within the event set; if it is non-empty, its lowest index gets its in-service bit set and its vectored output driven to 1. A masked line that rises is recorded as pending but not dispatched.
- R4: On a falling event, the eligible set is in-service within the event set; if non-empty, its lowest index has its in-service bit cleared and its vectored output driven to 0, even when another in-service line shares that output.
- R5: Line i drives output wire number cfg_vec[i*VEC_W +: VEC_W]; there are 2**VEC_W output wires (256 for the default 8-bit vector).
- R6: At most one event is handled per clock. Input changes are handled one line per clock, lowest-numbered changed line first, and the result appears on the outputs at the clock edge that handles it; later changes wait.
- R7: When no input change is waiting, a mask configuration change is an event: bits going from masked to unmasked form a rising event set (handled first), bits going from unmasked to masked form a falling event set; each acts on the lowest eligible bit only.
- R8: After reset all lines are masked and level sensitive, all vectors are 0, and the pending, in-service, last-seen and output vectors are all zero.
- R9: The line-count parameter must lie between 1 and 64 (elaboration fails otherwise); the pending and in-service outputs are exactly that many bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | NUM_LINES | Interrupt input level per line |
| cfg_edge | input | NUM_LINES | 1 = edge sensitive, 0 = level sensitive |
| cfg_mask | input | NUM_LINES | 1 = line masked |
| cfg_vec | input | NUM_LINES*VEC_W | Output vector per line, line i in bits [i*VEC_W +: VEC_W] |
| irq_out | output | 2**VEC_W | Vectored interrupt wires |
| pend_o | output | NUM_LINES | Raw pending vector |
| isr_o | output | NUM_LINES | In-service vector |

## Verification
A walking single-line pattern in level mode, first masked and then unmasked, separates mask gating from pending capture and shows the line-to-wire mapping through a reversed vector table. The same walk in edge mode shows pending bits accumulating across falls, and a held-high line shows that an unchanged input makes no event. Two lines changing together, two lines sharing one wire, and unmasking two pending lines at once expose the lowest-first order, the one-event-per-clock rule and the retire-lowers-shared-wire behaviour.

// File: rtl/vid_pkg.sv
package vid_pkg;
  localparam int unsigned VID_MAX_LINES = 64;

  // Kind of event handled in the current cycle
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_LINE   = 2'd1,
    EV_UNMASK = 2'd2,
    EV_MASK   = 2'd3
  } vid_ev_e;
endpackage

// File: rtl/vid_event_sel.sv
module vid_event_sel
  import vid_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] lseen,
  input  logic [N-1:0] mask_r,
  input  logic [N-1:0] cfg_mask,
  output vid_ev_e      ev_kind,
  output logic [N-1:0] ev_set,
  output logic         ev_lvl
);
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] chg, unm, newm;

  assign chg  = line_in ^ lseen;
  assign unm  = mask_r & ~cfg_mask;
  assign newm = ~mask_r & cfg_mask;

  always_comb begin
    ev_kind = EV_NONE;
    ev_set  = '0;
    ev_lvl  = 1'b0;
    if (|chg) begin
      // isolate the lowest changed line
      ev_kind = EV_LINE;
      ev_set  = chg & (~chg + ONE);
      ev_lvl  = |(line_in & ev_set);
    end else if (|unm) begin
      ev_kind = EV_UNMASK;
      ev_set  = unm;
      ev_lvl  = 1'b1;
    end else if (|newm) begin
      ev_kind = EV_MASK;
      ev_set  = newm;
      ev_lvl  = 1'b0;
    end
  end
endmodule

// File: rtl/vid_line_state.sv
module vid_line_state
  import vid_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  vid_ev_e      ev_kind,
  input  logic [N-1:0] ev_set,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] edge_r,
  output logic [N-1:0] lseen,
  output logic [N-1:0] pend,
  output logic [N-1:0] pend_nx
);
  logic [N-1:0] lseen_nx;
  logic         is_line;

  assign is_line = (ev_kind == EV_LINE);

  always_comb begin
    lseen_nx = lseen;
    pend_nx  = pend;
    if (is_line) begin
      lseen_nx = (lseen & ~ev_set) | (line_in & ev_set);
      // level lines copy the input; edge lines only set on a rise from 0
      pend_nx  = (pend & ~(ev_set & ~edge_r))
               | (ev_set & line_in & (~edge_r | ~lseen));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lseen <= '0;
      pend  <= '0;
    end else begin
      lseen <= lseen_nx;
      pend  <= pend_nx;
    end
  end
endmodule

// File: rtl/vid_dispatch.sv
module vid_dispatch
  import vid_pkg::*;
#(
  parameter int unsigned N    = 64,
  parameter int unsigned VW   = 8,
  parameter int unsigned NOUT = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  vid_ev_e         ev_kind,
  input  logic [N-1:0]    ev_set,
  input  logic            ev_lvl,
  input  logic [N-1:0]    pend_nx,
  input  logic [N-1:0]    mask_eff,
  input  logic [N*VW-1:0] vec_flat,
  output logic [N-1:0]    isr,
  output logic [NOUT-1:0] irq_out
);
  localparam logic [N-1:0] ONE = N'(1);

  logic          rise, fall;
  logic [N-1:0]  elig, sel;
  logic [VW-1:0] vec_pick;

  assign rise = ((ev_kind == EV_LINE) && ev_lvl) || (ev_kind == EV_UNMASK);
  assign fall = ((ev_kind == EV_LINE) && !ev_lvl) || (ev_kind == EV_MASK);

  always_comb begin
    elig = '0;
    if (rise)      elig = pend_nx & ~mask_eff & ev_set;
    else if (fall) elig = isr & ev_set;
    sel = elig & (~elig + ONE);
  end

  always_comb begin
    vec_pick = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (sel[i]) vec_pick = vec_pick | vec_flat[i*VW +: VW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr     <= '0;
      irq_out <= '0;
    end else if (|elig) begin
      isr               <= rise ? (isr | sel) : (isr & ~sel);
      irq_out[vec_pick] <= rise;
    end
  end
endmodule

// File: rtl/vec_irq_dispatch.sv
module vec_irq_dispatch
  import vid_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned VEC_W     = 8,
  localparam int unsigned NUM_OUTS = 1 << VEC_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       line_in,
  input  logic [NUM_LINES-1:0]       cfg_edge,
  input  logic [NUM_LINES-1:0]       cfg_mask,
  input  logic [NUM_LINES*VEC_W-1:0] cfg_vec,
  output logic [NUM_OUTS-1:0]        irq_out,
  output logic [NUM_LINES-1:0]       pend_o,
  output logic [NUM_LINES-1:0]       isr_o
);
  if (NUM_LINES < 1 || NUM_LINES > VID_MAX_LINES) begin : g_bad_count
    $error("vec_irq_dispatch: NUM_LINES out of range");
  end

  logic [NUM_LINES-1:0]       edge_r, mask_r, mask_eff;
  logic [NUM_LINES*VEC_W-1:0] vec_r;
  logic [NUM_LINES-1:0]       lseen, pend_nx, ev_set;
  vid_ev_e                    ev_kind;
  logic                       ev_lvl;

  // configuration capture; the mask only moves through mask events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_r <= '0;
      vec_r  <= '0;
      mask_r <= '1;
    end else begin
      edge_r <= cfg_edge;
      vec_r  <= cfg_vec;
      if (ev_kind == EV_UNMASK)    mask_r <= mask_r & cfg_mask;
      else if (ev_kind == EV_MASK) mask_r <= cfg_mask;
    end
  end

  assign mask_eff = (ev_kind == EV_UNMASK) ? (mask_r & cfg_mask) : mask_r;

  vid_event_sel #(.N(NUM_LINES)) u_sel (
    .line_in (line_in),
    .lseen   (lseen),
    .mask_r  (mask_r),
    .cfg_mask(cfg_mask),
    .ev_kind (ev_kind),
    .ev_set  (ev_set),
    .ev_lvl  (ev_lvl)
  );

  vid_line_state #(.N(NUM_LINES)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_kind(ev_kind),
    .ev_set (ev_set),
    .line_in(line_in),
    .edge_r (edge_r),
    .lseen  (lseen),
    .pend   (pend_o),
    .pend_nx(pend_nx)
  );

  vid_dispatch #(.N(NUM_LINES), .VW(VEC_W), .NOUT(NUM_OUTS)) u_disp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_kind (ev_kind),
    .ev_set  (ev_set),
    .ev_lvl  (ev_lvl),
    .pend_nx (pend_nx),
    .mask_eff(mask_eff),
    .vec_flat(vec_r),
    .isr     (isr_o),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/vid_checker.sv
module vid_checker #(
  parameter int unsigned N    = 64,
  parameter int unsigned NOUT = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    pend,
  input logic [N-1:0]    isr,
  input logic [N-1:0]    lseen,
  input logic [N-1:0]    edge_r,
  input logic [NOUT-1:0] irq_out
);
  // R6: one dispatch or retirement per clock
  a_r6_one_service_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr ^ $past(isr)) <= 1);

  // R5: at most one vectored wire moves per clock
  a_r5_one_wire_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out ^ $past(irq_out)) <= 1);

  // R3: a line enters service only while pending
  a_r3_service_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) & ~pend) == '0);

  // R3: entering service leaves some wire raised
  a_r3_service_drives_wire: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr & ~$past(isr))) |-> (|irq_out));

  // R1: an edge line becomes pending only together with a rise of its last-seen level
  a_r1_edge_pending_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & $past(edge_r) & ~(lseen & ~$past(lseen))) == '0);
endmodule

bind vec_irq_dispatch vid_checker #(.N(NUM_LINES), .NOUT(NUM_OUTS)) u_vid_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pend   (pend_o),
  .isr    (isr_o),
  .lseen  (lseen),
  .edge_r (edge_r),
  .irq_out(irq_out)
);

// File: tb/test_vec_irq_dispatch.sv
module test_vec_irq_dispatch;
  localparam int NL = 8;
  localparam int VW = 3;
  localparam int NO = 1 << VW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL-1:0]    line_in = '0;
  logic [NL-1:0]    cfg_edge = '0;
  logic [NL-1:0]    cfg_mask = '1;
  logic [NL*VW-1:0] cfg_vec = '0;
  logic [NO-1:0]    irq_out;
  logic [NL-1:0]    pend_o, isr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vec_irq_dispatch #(.NUM_LINES(NL), .VEC_W(VW)) i_vec_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_edge(cfg_edge),
    .cfg_mask(cfg_mask), .cfg_vec(cfg_vec), .irq_out(irq_out),
    .pend_o(pend_o), .isr_o(isr_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // line i -> wire 7-i
  function automatic logic [NL*VW-1:0] rev_map();
    logic [NL*VW-1:0] v;
    for (int i = 0; i < NL; i++) v[i*VW +: VW] = VW'(NL-1-i);
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; line_in = '0; cfg_edge = '0; cfg_mask = '1; cfg_vec = rev_map();
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R8 reset state, R9 widths
    chk("R8 irq", 64'(irq_out), 0);
    chk("R8 pend", 64'(pend_o), 0);
    chk("R8 isr", 64'(isr_o), 0);
    chk("R9 width", 64'($bits(pend_o) + $bits(isr_o)), 64'(2*NL));

    // masked level walk: pending follows, nothing dispatched
    for (int i = 0; i < NL; i++) begin
      line_in = NL'(1) << i; step();
      chk("R2 level pend set", 64'(pend_o), 64'(1) << i);
      chk("R3 masked no out", 64'(irq_out), 0);
      line_in = '0; step();
      chk("R2 level pend clr", 64'(pend_o), 0);
    end

    cfg_mask = '0; step(); step();
    chk("R7 unmask nothing pending", 64'(irq_out), 0);

    // unmasked level walk through reversed vectors
    for (int i = 0; i < NL; i++) begin
      line_in = NL'(1) << i; step();
      chk("R5 vectored wire", 64'(irq_out), 64'(1) << (NL-1-i));
      chk("R3 in service", 64'(isr_o), 64'(1) << i);
      line_in = '0; step();
      chk("R4 wire low", 64'(irq_out), 0);
      chk("R4 service clr", 64'(isr_o), 0);
    end

    // two lines together: lowest first, one per clock
    line_in = 8'h24; step();
    chk("R6 first only", 64'(isr_o), 64'h04);
    chk("R6 first wire", 64'(irq_out), 64'h20);
    step();
    chk("R6 second", 64'(isr_o), 64'h24);
    chk("R6 both wires", 64'(irq_out), 64'h24);
    line_in = '0; step();
    chk("R6 lowest retires first", 64'(isr_o), 64'h20);
    chk("R6 retire wire", 64'(irq_out), 64'h04);
    step();
    chk("R4 all retired", 64'(isr_o), 0);

    // shared wire: lines 1 and 3 on wire 6
    cfg_vec[3*VW +: VW] = 3'd6; step();
    line_in = 8'h0A; step(); step();
    chk("R5 shared service", 64'(isr_o), 64'h0A);
    chk("R5 shared wire", 64'(irq_out), 64'h40);
    line_in = 8'h08; step();
    chk("R4 shared service", 64'(isr_o), 64'h08);
    chk("R4 shared wire lowered", 64'(irq_out), 0);
    line_in = '0; step();
    cfg_vec = rev_map(); step();

    // mask events
    cfg_mask = 8'h50; step();
    line_in = 8'h50; step(); step();
    chk("R3 masked pend", 64'(pend_o), 64'h50);
    chk("R3 masked isr", 64'(isr_o), 0);
    cfg_mask = '0; step();
    chk("R7 unmask lowest", 64'(isr_o), 64'h10);
    chk("R7 unmask wire", 64'(irq_out), 64'h08);
    step();
    chk("R7 no second dispatch", 64'(isr_o), 64'h10);
    cfg_mask = 8'h50; step();
    chk("R7 mask retires", 64'(isr_o), 0);
    chk("R7 mask wire", 64'(irq_out), 0);
    line_in = '0; step(); step();
    chk("R2 pend cleared", 64'(pend_o), 0);

    // edge walk
    do_reset();
    cfg_mask = '0; cfg_edge = '1; step(); step();
    for (int i = 0; i < NL; i++) begin
      line_in = NL'(1) << i; step();
      chk("R1 edge pend", 64'(pend_o), (64'(2) << i) - 1);
      chk("R3 edge service", 64'(isr_o), 64'(1) << i);
      chk("R5 edge wire", 64'(irq_out), 64'(1) << (NL-1-i));
      line_in = '0; step();
      chk("R1 edge pend kept", 64'(pend_o), (64'(2) << i) - 1);
      chk("R4 edge retire", 64'(irq_out), 0);
    end
    line_in = 8'h01; step();
    chk("R3 pending line redispatch", 64'(isr_o), 64'h01);
    step();
    chk("R6 held level no event", 64'(isr_o), 64'h01);
    line_in = '0; step();
    chk("R4 held retire", 64'(isr_o), 0);

    // edge while masked, dispatched on unmask
    do_reset();
    cfg_edge = '1; step();
    line_in = 8'h08; step();
    chk("R1 masked edge pend", 64'(pend_o), 64'h08);
    chk("R3 masked edge no out", 64'(irq_out), 0);
    line_in = '0; step();
    chk("R1 edge fall keeps", 64'(pend_o), 64'h08);
    cfg_mask = '0; step();
    chk("R7 late dispatch", 64'(isr_o), 64'h08);
    chk("R7 late wire", 64'(irq_out), 64'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule